// File: doc/BRIEF.md
# Reed-Solomon Corrected-Error Statistics Monitor

This block runs alongside a (204,188) Reed-Solomon decoder, a shortened form of a (255,239) code that can repair at most eight bytes in each 204-byte frame. While a frame is being corrected, the decoder presents each non-zero error magnitude it applies on `err_valid`/`err_mag`. When the frame is finished it pulses `frame_end` and reports on `frame_uncorr` whether decoding failed, which happens when the frame held more than eight bad bytes. The monitor turns this stream into two statistics: the number of bits that were actually corrected and the number of frames that could not be repaired.

Each error byte contributes its population count, because every set bit in a magnitude marks one flipped bit. The bits of a frame are committed only if that frame decoded correctly. Both tallies run over a measurement window whose length, in frames, is set by the host. When the window closes, the totals are copied to output registers and a one-cycle done pulse is raised. The running counters then start again from zero, which lets the host form a post-decoder bit error rate.

Top module: `rs_err_monitor`

## Requirements
- R1: Each cycle with `err_valid`=1 adds the number of ones in the 8-bit `err_mag` to the total of the current frame. A byte presented in the same cycle as `frame_end` belongs to the frame that is ending.
- R2: At `frame_end` with `frame_uncorr`=0, the frame's bit total is added to the running bit-error count.
- R3: At `frame_end` with `frame_uncorr`=1, the running uncorrectable-frame count rises by one and the frame's bits are dropped.
- R4: After `period_len` frame ends since the window started, `period_done` is high for exactly the following cycle. In that same cycle `bit_errs` and `uncorr_frames` show the window totals, including the last frame. These outputs then hold until the next window closes.
- R5: The running counts restart from zero when a window closes, so each window's totals exclude every earlier window.
- R6: The bit count stops at 2^BIT_W-1 and the uncorrectable count stops at 2^UNC_W-1. Neither wraps.
- R7: `period_wr`=1 loads `period_len` and restarts the measurement at once. It discards the running counts, the partial frame and the frame position, including any byte or `frame_end` in the same cycle. It causes no done pulse and leaves `bit_errs`/`uncorr_frames` unchanged.
- R8: A window length of 0 acts as a length of 1.
- R9: After reset, `bit_errs`=0, `uncorr_frames`=0, `period_done`=0, and the window length is DEF_PERIOD (default 8).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| err_valid | input | 1 | A corrected error magnitude is presented |
| err_mag | input | 8 | Error magnitude applied to one byte |
| frame_end | input | 1 | Last cycle of a frame, status valid |
| frame_uncorr | input | 1 | Frame could not be corrected (with frame_end) |
| period_wr | input | 1 | Load a new window length and restart |
| period_len | input | PER_W (16) | Window length in frames |
| bit_errs | output | BIT_W (16) | Corrected bits in the last completed window |
| uncorr_frames | output | UNC_W (10) | Uncorrectable frames in the last completed window |
| period_done | output | 1 | One-cycle pulse when a window closes |

## Verification
The hardest condition to reach from the ports is counter saturation. With 64 corrected bits at most per frame, the bit counter needs more than a thousand frames inside one window before it reaches its ceiling. The bench therefore programs a 2000-frame window, feeds 1100 frames of eight all-ones magnitudes, and then pads the window with empty frames. A 1100-frame window of failed frames drives the other counter past its limit in the same way. A window write that lands in the same cycle as a frame end and an error byte is driven directly, to show that all three are discarded.

// File: rtl/rs_mon_pkg.sv
package rs_mon_pkg;
  typedef logic [7:0] err_mag_t;

  // number of flipped bits represented by one error magnitude
  function automatic logic [3:0] pop8(input err_mag_t m);
    logic [3:0] s;
    s = '0;
    for (int i = 0; i < 8; i++) s = s + {3'b000, m[i]};
    return s;
  endfunction
endpackage

// File: rtl/rs_frame_acc.sv
module rs_frame_acc
  import rs_mon_pkg::*;
#(
  parameter int FRAME_BYTES = 204,
  localparam int ACC_W = $clog2(FRAME_BYTES * 8 + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             byte_vld,
  input  err_mag_t         mag,
  input  logic             frame_end,
  output logic [ACC_W-1:0] frame_bits
);
  logic [ACC_W-1:0] acc;
  logic [3:0]       byte_bits;
  logic [ACC_W:0]   wide;

  assign byte_bits  = byte_vld ? pop8(mag) : 4'd0;
  assign wide       = {1'b0, acc} + (ACC_W + 1)'(byte_bits);
  assign frame_bits = wide[ACC_W] ? '1 : wide[ACC_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                acc <= '0;
    else if (clr || frame_end) acc <= '0;
    else                       acc <= frame_bits;
  end

  // R1: a new frame always starts from an empty total
  assert_frame_restart_R1: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> acc == '0);
endmodule

// File: rtl/rs_sat_counter.sv
module rs_sat_counter #(
  parameter int W  = 16,
  parameter int IW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          en,
  input  logic [IW-1:0] inc,
  output logic [W-1:0]  cnt,
  output logic [W-1:0]  sum
);
  logic [W:0]   wide;
  logic [W-1:0] nxt;

  assign wide = {1'b0, cnt} + (W + 1)'(inc);
  assign nxt  = wide[W] ? '1 : wide[W-1:0];
  assign sum  = en ? nxt : cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (en)  cnt <= nxt;
  end

  assert_no_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !clr) |=> cnt >= $past(cnt));
  assert_hold_at_max_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !clr && cnt == '1) |=> cnt == '1);
endmodule

// File: rtl/rs_period_ctrl.sv
module rs_period_ctrl #(
  parameter int PER_W      = 16,
  parameter int DEF_PERIOD = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             period_wr,
  input  logic [PER_W-1:0] period_len,
  input  logic             frame_end,
  output logic             period_end
);
  logic [PER_W-1:0] per_q;
  logic [PER_W-1:0] frm_cnt;
  logic [PER_W-1:0] eff_per;
  logic             last_frame;

  assign eff_per    = (per_q == '0) ? PER_W'(1) : per_q;
  assign last_frame = (frm_cnt == eff_per - PER_W'(1));
  assign period_end = frame_end && !period_wr && last_frame;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_q   <= PER_W'(DEF_PERIOD);
      frm_cnt <= '0;
    end else if (period_wr) begin
      per_q   <= period_len;
      frm_cnt <= '0;
    end else if (frame_end) begin
      frm_cnt <= last_frame ? '0 : frm_cnt + PER_W'(1);
    end
  end

  assert_pos_in_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
    frm_cnt < eff_per);
  assert_write_restarts_R7: assert property (@(posedge clk) disable iff (!rst_n)
    period_wr |=> frm_cnt == '0);
endmodule

// File: rtl/rs_err_monitor.sv
module rs_err_monitor
  import rs_mon_pkg::*;
#(
  parameter int FRAME_BYTES = 204,
  parameter int PER_W       = 16,
  parameter int BIT_W       = 16,
  parameter int UNC_W       = 10,
  parameter int DEF_PERIOD  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             err_valid,
  input  logic [7:0]       err_mag,
  input  logic             frame_end,
  input  logic             frame_uncorr,
  input  logic             period_wr,
  input  logic [PER_W-1:0] period_len,
  output logic [BIT_W-1:0] bit_errs,
  output logic [UNC_W-1:0] uncorr_frames,
  output logic             period_done
);
  localparam int ACC_W = $clog2(FRAME_BYTES * 8 + 1);

  // named internal events
  logic             period_end;
  logic             cnt_clr;
  logic             good_frame;
  logic             bad_frame;
  logic [ACC_W-1:0] frame_bits;
  logic [BIT_W-1:0] bit_cnt, bit_sum;
  logic [UNC_W-1:0] unc_cnt, unc_sum;

  assign good_frame = frame_end && !frame_uncorr && !period_wr;
  assign bad_frame  = frame_end && frame_uncorr && !period_wr;
  assign cnt_clr    = period_wr || period_end;

  rs_frame_acc #(.FRAME_BYTES(FRAME_BYTES)) u_frame (
    .clk(clk), .rst_n(rst_n), .clr(period_wr), .byte_vld(err_valid),
    .mag(err_mag), .frame_end(frame_end), .frame_bits(frame_bits)
  );

  rs_period_ctrl #(.PER_W(PER_W), .DEF_PERIOD(DEF_PERIOD)) u_period (
    .clk(clk), .rst_n(rst_n), .period_wr(period_wr), .period_len(period_len),
    .frame_end(frame_end), .period_end(period_end)
  );

  rs_sat_counter #(.W(BIT_W), .IW(ACC_W)) u_bit_cnt (
    .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .en(good_frame),
    .inc(frame_bits), .cnt(bit_cnt), .sum(bit_sum)
  );

  rs_sat_counter #(.W(UNC_W), .IW(1)) u_unc_cnt (
    .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .en(bad_frame),
    .inc(1'b1), .cnt(unc_cnt), .sum(unc_sum)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_errs      <= '0;
      uncorr_frames <= '0;
      period_done   <= 1'b0;
    end else begin
      period_done <= period_end;
      if (period_end) begin
        bit_errs      <= bit_sum;
        uncorr_frames <= unc_sum;
      end
    end
  end

  assert_restart_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    period_done |-> (bit_cnt == '0 && unc_cnt == '0));
  assert_wr_no_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    period_wr |=> !period_done);
  assert_hold_between_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !period_done |-> ($stable(bit_errs) && $stable(uncorr_frames)));
  assert_bad_skips_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bad_frame && !period_end) |=> bit_cnt == $past(bit_cnt));
endmodule

// File: tb/rs_err_monitor_tb.sv
module rs_err_monitor_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        err_valid = 1'b0;
  logic [7:0]  err_mag = '0;
  logic        frame_end = 1'b0;
  logic        frame_uncorr = 1'b0;
  logic        period_wr = 1'b0;
  logic [15:0] period_len = '0;
  logic [15:0] bit_errs;
  logic [9:0]  uncorr_frames;
  logic        period_done;

  int n_chk = 0;
  int n_err = 0;
  logic        got_done;
  logic [15:0] got_bits;
  logic [9:0]  got_unc;

  always #(CLK_PERIOD / 2) clk = ~clk;

  rs_err_monitor u_dut (
    .clk(clk), .rst_n(rst_n), .err_valid(err_valid), .err_mag(err_mag),
    .frame_end(frame_end), .frame_uncorr(frame_uncorr), .period_wr(period_wr),
    .period_len(period_len), .bit_errs(bit_errs), .uncorr_frames(uncorr_frames),
    .period_done(period_done)
  );

  // {uncorrectable, byte count, magnitudes (byte 0 in the low bits)}
  localparam logic [68:0] VEC [8] = '{
    {1'b0, 4'd2, 64'h0000_0000_0000_0F01},
    {1'b1, 4'd3, 64'h0000_0000_00FF_FFFF},
    {1'b0, 4'd0, 64'h0000_0000_0000_0000},
    {1'b0, 4'd8, 64'h8040_2010_0804_0201},
    {1'b0, 4'd1, 64'h0000_0000_0000_00AA},
    {1'b0, 4'd4, 64'h0000_0000_7733_1155},
    {1'b1, 4'd0, 64'h0000_0000_0000_0000},
    {1'b1, 4'd2, 64'h0000_0000_0000_C3FE}
  };

  function automatic int ones_in(input logic [63:0] mags, input int n);
    int c = 0;
    for (int b = 0; b < n; b++) begin
      logic [7:0] v = mags[8*b +: 8];
      while (v != 0) begin
        v = v & (v - 8'd1);
        c++;
      end
    end
    return c;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send_frame(input logic [63:0] mags, input int n, input bit unc);
    if (n == 0) begin
      @(negedge clk);
      frame_end = 1'b1;
      frame_uncorr = unc;
    end else begin
      for (int i = 0; i < n; i++) begin
        @(negedge clk);
        err_valid = 1'b1;
        err_mag = mags[8*i +: 8];
        frame_end = (i == n - 1);
        frame_uncorr = unc;
      end
    end
    @(negedge clk);
    got_done = period_done;
    got_bits = bit_errs;
    got_unc = uncorr_frames;
    err_valid = 1'b0;
    frame_end = 1'b0;
    frame_uncorr = 1'b0;
  endtask

  task automatic write_period(input int len);
    @(negedge clk);
    period_wr = 1'b1;
    period_len = 16'(len);
    @(negedge clk);
    period_wr = 1'b0;
  endtask

  task automatic finish_run;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int eb, eu;
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9 bit_errs after reset", bit_errs, 0);
    chk("R9 uncorr_frames after reset", uncorr_frames, 0);
    chk("R9 period_done after reset", period_done, 0);
    rst_n = 1'b1;

    // R9: default window of 8 frames, 2 bits each
    for (int f = 0; f < 7; f++) send_frame(64'h03, 1, 1'b0);
    chk("R9 no done before frame 8", got_done, 0);
    send_frame(64'h03, 1, 1'b0);
    chk("R9 done after frame 8", got_done, 1);
    chk("R2 bits over default window", got_bits, 16);
    chk("R3 no uncorrectable in default window", got_unc, 0);

    // table walk: windows of 4 frames (R1, R2, R3, R4, R5)
    write_period(4);
    eb = 0;
    eu = 0;
    for (int k = 0; k < 8; k++) begin
      send_frame(VEC[k][63:0], int'(VEC[k][67:64]), VEC[k][68]);
      if (VEC[k][68]) eu++;
      else eb += ones_in(VEC[k][63:0], int'(VEC[k][67:64]));
      if (k % 4 == 3) begin
        chk("R4 done at window end", got_done, 1);
        chk("R1 R2 R5 window bit total", got_bits, eb);
        chk("R3 R5 window uncorrectable total", got_unc, eu);
        eb = 0;
        eu = 0;
      end else begin
        chk("R4 no done inside window", got_done, 0);
      end
    end

    // R7: write mid-window, colliding with a frame end and a byte
    send_frame(64'hFF, 1, 1'b0);
    send_frame(64'h0F, 1, 1'b0);
    @(negedge clk);
    err_valid = 1'b1;
    err_mag = 8'hFF;
    @(negedge clk);
    err_valid = 1'b1;
    err_mag = 8'hFF;
    frame_end = 1'b1;
    period_wr = 1'b1;
    period_len = 16'd3;
    @(negedge clk);
    err_valid = 1'b0;
    frame_end = 1'b0;
    period_wr = 1'b0;
    @(negedge clk);
    chk("R7 no done after write", period_done, 0);
    chk("R7 bit_errs kept after write", bit_errs, ones_in(VEC[4][63:0], 1) +
        ones_in(VEC[5][63:0], 4));
    chk("R7 uncorr_frames kept after write", uncorr_frames, 2);
    send_frame(64'h01, 1, 1'b0);
    send_frame(64'h01, 1, 1'b1);
    chk("R7 no done at new frame 2", got_done, 0);
    send_frame(64'h0703, 2, 1'b0);
    chk("R7 done at new length 3", got_done, 1);
    chk("R7 only post-write bits counted", got_bits, 6);
    chk("R7 only post-write uncorrectable counted", got_unc, 1);

    // R8: length 0 behaves as 1
    write_period(0);
    send_frame(64'h07, 1, 1'b0);
    chk("R8 done every frame", got_done, 1);
    chk("R8 bits of single frame", got_bits, 3);
    send_frame(64'hFF, 1, 1'b1);
    chk("R8 done on failed frame", got_done, 1);
    chk("R8 R3 failed frame adds no bits", got_bits, 0);
    chk("R8 failed frame counted", got_unc, 1);

    // R6: bit counter saturation inside a 2000-frame window
    write_period(2000);
    for (int f = 0; f < 1100; f++) send_frame('1, 8, 1'b0);
    for (int f = 0; f < 899; f++) send_frame('0, 0, 1'b0);
    chk("R6 no done before frame 2000", got_done, 0);
    send_frame('0, 0, 1'b0);
    chk("R6 done at frame 2000", got_done, 1);
    chk("R6 bit count saturated", got_bits, 65535);
    chk("R6 no uncorrectable", got_unc, 0);

    // R6: uncorrectable counter saturation, bits dropped (R3)
    write_period(1100);
    for (int f = 0; f < 1100; f++) send_frame(64'hFF, 1, 1'b1);
    chk("R6 done at frame 1100", got_done, 1);
    chk("R6 uncorrectable count saturated", got_unc, 1023);
    chk("R3 failed frames add no bits", got_bits, 0);

    finish_run();
  end
endmodule